// File: doc/BRIEF.md
# Host Bridge Register Bank

This block is the register bank of a PCI-style host bridge, reached from the CPU through a simple 32-bit register bus with word offsets, byte enables, a ready signal and an error pulse. It keeps a local copy of the bridge's own 256-byte configuration header. It holds an indirect configuration address register and a data port. An access to the data port becomes a configuration cycle toward an external bus engine, over a request/acknowledge interface.

It also holds a memory base register and an I/O base register. The I/O base register places a relocatable 256 KiB I/O window, and a decoder flags CPU addresses that fall inside it. A small router folds the level interrupts of four device slots onto four interrupt lines. Each slot goes to a line chosen from its device/function number.

Register accesses complete in the cycle they are presented. A data-port access waits for the bus engine. An access with partial byte enables is rejected with an error.

Top module: `hbr_regbank`

## Requirements
- R1: Offsets 0x000 to 0x0FC read and write the 64 words of the local configuration header. The header byte at offset 4n+k sits in bits 8k+7:8k of word n (little-endian), and a written word reads back unchanged.
- R2: After reset the header word at 0x004 reads 0x0290_0080 and every other header word reads 0. The command field (bits 15:0) has only the wait-cycle-control bit 7 set. The status field (bits 31:16) has the capability-list bit 4, the fast back-to-back bit 7 and the medium select-timing value 01 in bits 10:9.
- R3: Offset 0x1C0 is the configuration address register. It resets to 0 and stores and returns all 32 bits.
- R4: Offset 0x1C4 is the memory base register. It resets to 0. A write keeps only bits 31:24 and bit 0, and all other bits read 0.
- R5: Offset 0x1C8 is the I/O base register. It resets to 0xFE24_0000 and keeps bits 31:18 and bit 0. A write is taken only when bits 31:18 of the new value differ from the stored ones. A write that changes only bit 0, or nothing, leaves the register unchanged.
- R6: `io_hit_o` is high exactly when bits 31:18 of `cpu_addr_i` equal bits 31:18 of the I/O base register, so the window is 0x40000 bytes long.
- R7: A full write to offset 0x220 raises `cfg_req_o` with `cfg_we_o`=1, `cfg_addr_o` equal to the configuration address register and `cfg_wdata_o` equal to the written data. `ready_o` stays low until the cycle in which `cfg_ack_i` is high.
- R8: A full read of offset 0x220 raises `cfg_req_o` with `cfg_we_o`=0 and returns `cfg_rdata_i` on `rdata_o` in the acknowledge cycle, with `ready_o` high.
- R9: Reads of unmapped offsets (0x100 to 0x1BC, 0x1CC to 0x21C, 0x224 and above) return 0 with `ready_o` high. Writes to them change no register.
- R10: An access with `be_i` not equal to 4'hF is not performed. It completes at once with `ready_o` and `err_o` high for that cycle, and it raises no configuration request.
- R11: Interrupt line L (`irq_o[L]`) is the OR of `slot_irq_i[s]` over all slots s whose device/function number (8 bits of `slot_fn_i` at 8s) shifted right by 3, modulo 4, equals L. Levels pass through without a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | CPU access request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Word offset (byte offset bits 9:2) |
| be_i | input | 4 | Byte enables; only 4'hF is performed |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid when ready_o is high |
| ready_o | output | 1 | Access completes this cycle |
| err_o | output | 1 | Access rejected (partial byte enables) |
| cfg_req_o | output | 1 | Configuration cycle request |
| cfg_we_o | output | 1 | Configuration cycle is a write |
| cfg_addr_o | output | 32 | Configuration cycle address |
| cfg_wdata_o | output | 32 | Configuration write data |
| cfg_ack_i | input | 1 | Configuration cycle acknowledge |
| cfg_rdata_i | input | 32 | Configuration read data, valid with ack |
| cpu_addr_i | input | 32 | CPU address to test against the I/O window |
| io_hit_o | output | 1 | cpu_addr_i lies in the I/O window |
| slot_fn_i | input | 32 | Device/function number of each slot, 8 bits per slot |
| slot_irq_i | input | 4 | Interrupt level of each slot |
| irq_o | output | 4 | Routed interrupt lines |

## Verification
The checker watches every cycle for the following. A rejected access always completes with an error and never reaches the bus engine. A pending data-port access keeps ready low while the engine is silent. Memory base reads never show unkept bits. Unmapped reads return zero. The window hit never moves unless the CPU address or the I/O base changes. Quiet slots leave every line low. The stored values behind each offset, the ignored same-window I/O base writes, the exact address and data handed to the engine, the number of wait cycles and the slot-to-line mapping are shown only by the bench's scenarios against its reference model.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  localparam int unsigned WOFF_W = 8;  // word offset width (byte offset 9:2)

  localparam logic [WOFF_W-1:0] WOFF_CFG_ADDR = 8'h70;  // 0x1C0
  localparam logic [WOFF_W-1:0] WOFF_MEM_BASE = 8'h71;  // 0x1C4
  localparam logic [WOFF_W-1:0] WOFF_IO_BASE  = 8'h72;  // 0x1C8
  localparam logic [WOFF_W-1:0] WOFF_CFG_PORT = 8'h88;  // 0x220

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_HDR,
    SEL_CADDR,
    SEL_MBASE,
    SEL_IOBASE,
    SEL_PORT
  } sel_e;
endpackage

// File: rtl/hbr_cfg_hdr.sv
module hbr_cfg_hdr #(
  parameter int unsigned WORDS     = 64,
  parameter int unsigned CMD_WORD  = 1,
  parameter logic [15:0] CMD_RST   = 16'h0080,
  parameter logic [15:0] STAT_RST  = 16'h0290,
  localparam int unsigned IDX_W    = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);
  logic [31:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) begin
        mem_q[i] <= (i == CMD_WORD) ? {STAT_RST, CMD_RST} : 32'h0;
      end
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  // byte 4n+k of the header lives in lane k of word n
  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/hbr_io_win.sv
module hbr_io_win #(
  parameter int unsigned WIN_BITS = 18,
  parameter logic [31:0] BASE_RST = 32'hFE24_0000,
  localparam logic [31:0] HI_MASK = ~((32'h1 << WIN_BITS) - 32'h1),
  localparam logic [31:0] KEEP    = HI_MASK | 32'h1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] cpu_addr_i,
  output logic [31:0] base_o,
  output logic        hit_o
);
  logic [31:0] base_q;
  logic        moved;

  assign moved = (wdata_i & HI_MASK) != (base_q & HI_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             base_q <= BASE_RST & KEEP;
    else if (we_i && moved)  base_q <= wdata_i & KEEP;
  end

  assign base_o = base_q;
  assign hit_o  = (cpu_addr_i & HI_MASK) == (base_q & HI_MASK);
endmodule

// File: rtl/hbr_irq_route.sv
module hbr_irq_route #(
  parameter int unsigned N_SLOTS = 4,
  parameter int unsigned N_LINES = 4,
  parameter int unsigned FN_W    = 8
) (
  input  logic [N_SLOTS*FN_W-1:0] slot_fn_i,
  input  logic [N_SLOTS-1:0]      slot_irq_i,
  output logic [N_LINES-1:0]      irq_o
);
  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    always_comb begin
      irq_o[l] = 1'b0;
      for (int s = 0; s < N_SLOTS; s++) begin
        if ((int'(slot_fn_i[s*FN_W +: FN_W] >> 3) % N_LINES) == l)
          irq_o[l] = irq_o[l] | slot_irq_i[s];
      end
    end
  end
endmodule

// File: rtl/hbr_regbank.sv
module hbr_regbank
  import hbr_pkg::*;
#(
  parameter int unsigned HDR_WORDS = 64,
  parameter int unsigned WIN_BITS  = 18,
  parameter logic [31:0] IO_RST    = 32'hFE24_0000,
  parameter logic [31:0] MEM_KEEP  = 32'hFF00_0001,
  parameter int unsigned N_SLOTS   = 4,
  parameter int unsigned N_LINES   = 4,
  parameter int unsigned FN_W      = 8,
  localparam int unsigned IDX_W    = $clog2(HDR_WORDS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [WOFF_W-1:0]       addr_i,
  input  logic [3:0]              be_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  output logic                    ready_o,
  output logic                    err_o,
  output logic                    cfg_req_o,
  output logic                    cfg_we_o,
  output logic [31:0]             cfg_addr_o,
  output logic [31:0]             cfg_wdata_o,
  input  logic                    cfg_ack_i,
  input  logic [31:0]             cfg_rdata_i,
  input  logic [31:0]             cpu_addr_i,
  output logic                    io_hit_o,
  input  logic [N_SLOTS*FN_W-1:0] slot_fn_i,
  input  logic [N_SLOTS-1:0]      slot_irq_i,
  output logic [N_LINES-1:0]      irq_o
);
  sel_e        sel;
  logic        full, go, wr;
  logic [31:0] caddr_q, mbase_q, hdr_rd, iobase;

  always_comb begin
    if (addr_i < WOFF_W'(HDR_WORDS)) sel = SEL_HDR;
    else begin
      unique case (addr_i)
        WOFF_CFG_ADDR: sel = SEL_CADDR;
        WOFF_MEM_BASE: sel = SEL_MBASE;
        WOFF_IO_BASE:  sel = SEL_IOBASE;
        WOFF_CFG_PORT: sel = SEL_PORT;
        default:       sel = SEL_NONE;
      endcase
    end
  end

  assign full = &be_i;
  assign go   = req_i && full;
  assign wr   = go && we_i;

  hbr_cfg_hdr #(.WORDS(HDR_WORDS)) i_hdr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr && sel == SEL_HDR),
    .idx_i   (addr_i[IDX_W-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (hdr_rd)
  );

  hbr_io_win #(.WIN_BITS(WIN_BITS), .BASE_RST(IO_RST)) i_io_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (wr && sel == SEL_IOBASE),
    .wdata_i    (wdata_i),
    .cpu_addr_i (cpu_addr_i),
    .base_o     (iobase),
    .hit_o      (io_hit_o)
  );

  hbr_irq_route #(.N_SLOTS(N_SLOTS), .N_LINES(N_LINES), .FN_W(FN_W)) i_irq (
    .slot_fn_i  (slot_fn_i),
    .slot_irq_i (slot_irq_i),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      caddr_q <= '0;
      mbase_q <= '0;
    end else if (wr) begin
      if (sel == SEL_CADDR) caddr_q <= wdata_i;
      if (sel == SEL_MBASE) mbase_q <= wdata_i & MEM_KEEP;
    end
  end

  // data port passes straight through to the bus engine
  assign cfg_req_o   = go && sel == SEL_PORT;
  assign cfg_we_o    = we_i;
  assign cfg_addr_o  = caddr_q;
  assign cfg_wdata_o = wdata_i;

  assign ready_o = req_i && (!full || sel != SEL_PORT || cfg_ack_i);
  assign err_o   = req_i && !full;

  always_comb begin
    rdata_o = '0;
    if (go && !we_i) begin
      unique case (sel)
        SEL_HDR:    rdata_o = hdr_rd;
        SEL_CADDR:  rdata_o = caddr_q;
        SEL_MBASE:  rdata_o = mbase_q;
        SEL_IOBASE: rdata_o = iobase;
        SEL_PORT:   rdata_o = cfg_ack_i ? cfg_rdata_i : 32'h0;
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/hbr_regbank_chk.sv
module hbr_regbank_chk #(
  parameter logic [31:0] MEM_KEEP = 32'hFF00_0001
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [7:0]  addr_i,
  input logic [3:0]  be_i,
  input logic [31:0] rdata_o,
  input logic        ready_o,
  input logic        err_o,
  input logic        cfg_req_o,
  input logic        cfg_ack_i,
  input logic [31:0] cpu_addr_i,
  input logic        io_hit_o,
  input logic [3:0]  slot_irq_i,
  input logic [3:0]  irq_o
);
  logic rd_full, io_wr, unmapped;
  assign rd_full  = req_i && !we_i && be_i == 4'hF;
  assign io_wr    = req_i && we_i && be_i == 4'hF && addr_i == 8'h72;
  assign unmapped = addr_i >= 8'h40 && addr_i != 8'h70 && addr_i != 8'h71 &&
                    addr_i != 8'h72 && addr_i != 8'h88;

  // R10
  partial_be_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && be_i != 4'hF) |-> (err_o && ready_o && !cfg_req_o));

  // R7
  port_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && be_i == 4'hF && addr_i == 8'h88 && !cfg_ack_i) |-> (cfg_req_o && !ready_o));

  // R4
  mem_base_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_full && addr_i == 8'h71) |-> ((rdata_o & ~MEM_KEEP) == 32'h0));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_full && unmapped) |-> (rdata_o == 32'h0 && ready_o && !err_o));

  // R6
  win_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(io_wr) && $stable(cpu_addr_i)) |-> $stable(io_hit_o));

  // R11
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_o) <= $countones(slot_irq_i));
endmodule

bind hbr_regbank hbr_regbank_chk #(.MEM_KEEP(MEM_KEEP)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .be_i       (be_i),
  .rdata_o    (rdata_o),
  .ready_o    (ready_o),
  .err_o      (err_o),
  .cfg_req_o  (cfg_req_o),
  .cfg_ack_i  (cfg_ack_i),
  .cpu_addr_i (cpu_addr_i),
  .io_hit_o   (io_hit_o),
  .slot_irq_i (slot_irq_i),
  .irq_o      (irq_o)
);

// File: tb/test_hbr_regbank.sv
`timescale 1ns/1ps
module test_hbr_regbank;
  localparam int LAT = 3;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req = 0, we = 0;
  logic [7:0]  addr = 0;
  logic [3:0]  be = 0;
  logic [31:0] wdata = 0, rdata;
  logic        ready, err;
  logic        cfg_req, cfg_we, cfg_ack = 0;
  logic [31:0] cfg_addr, cfg_wdata, cfg_rdata = 0;
  logic [31:0] cpu_addr = 0;
  logic        io_hit;
  logic [31:0] slot_fn = 0;
  logic [3:0]  slot_irq = 0, irq;

  int total = 0, bad = 0;
  bit done = 0, run_cmp = 0;

  // reference state
  logic [31:0] m_iobase = 32'hFE24_0000;
  int          eng_wr = 0, eng_rd = 0, eng_cnt = 0;
  logic [31:0] eng_addr = 0, eng_data = 0;

  always #10 clk = ~clk;

  hbr_regbank i_hbr_regbank (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready), .err_o(err),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_addr_o(cfg_addr),
    .cfg_wdata_o(cfg_wdata), .cfg_ack_i(cfg_ack), .cfg_rdata_i(cfg_rdata),
    .cpu_addr_i(cpu_addr), .io_hit_o(io_hit), .slot_fn_i(slot_fn),
    .slot_irq_i(slot_irq), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // bus engine model: acks after LAT sampled request cycles
  always @(posedge clk) begin
    if (cfg_ack) begin
      #1 cfg_ack = 0; eng_cnt = 0;
    end else if (cfg_req) begin
      eng_cnt++;
      if (eng_cnt >= LAT) begin
        eng_addr = cfg_addr;
        if (cfg_we) begin eng_wr++; eng_data = cfg_wdata; end
        else eng_rd++;
        #1 cfg_rdata = cfg_addr ^ 32'h5A5A_0F0F; cfg_ack = 1;
      end
    end
  end

  function automatic logic [3:0] irq_exp();
    logic [3:0] r = 0;
    for (int s = 0; s < 4; s++)
      if (slot_irq[s]) r[(slot_fn[s*8 +: 8] >> 3) % 4] = 1'b1;
    return r;
  endfunction

  // per-clock comparison of the window decoder and router
  always @(posedge clk) begin
    #15;
    if (run_cmp) begin
      chk("R6 io_hit", {31'h0, io_hit},
          {31'h0, (cpu_addr[31:18] == m_iobase[31:18])});
      chk("R11 irq", {28'h0, irq}, {28'h0, irq_exp()});
    end
  end

  task automatic acc(input logic w, input logic [9:0] off, input logic [31:0] d,
                     input logic [3:0] b, output logic [31:0] rd,
                     output logic er, output int waits);
    @(negedge clk);
    req = 1; we = w; addr = off[9:2]; wdata = d; be = b; waits = 0;
    forever begin
      #9;
      if (ready) break;
      waits++;
      @(negedge clk);
    end
    rd = rdata; er = err;
    @(posedge clk);
    if (w && b == 4'hF && off == 10'h1C8 && d[31:18] != m_iobase[31:18])
      m_iobase = d & 32'hFFFC_0001;
    #1 req = 0; we = 0;
  endtask

  logic [31:0] rd;
  logic        er;
  int          wt;

  initial begin
    #50000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    run_cmp = 1;

    // R2 / R3 / R4 / R5 reset values
    acc(0, 10'h004, 0, 4'hF, rd, er, wt); chk("R2 hdr cmd/status", rd, 32'h0290_0080);
    acc(0, 10'h000, 0, 4'hF, rd, er, wt); chk("R2 hdr word0", rd, 32'h0);
    acc(0, 10'h1C0, 0, 4'hF, rd, er, wt); chk("R3 caddr reset", rd, 32'h0);
    acc(0, 10'h1C4, 0, 4'hF, rd, er, wt); chk("R4 mbase reset", rd, 32'h0);
    acc(0, 10'h1C8, 0, 4'hF, rd, er, wt); chk("R5 iobase reset", rd, 32'hFE24_0000);
    cpu_addr = 32'hFE27_FFFC; @(negedge clk);

    // R1 header words, byte lanes little-endian
    acc(1, 10'h010, 32'h4433_2211, 4'hF, rd, er, wt);
    acc(1, 10'h0FC, 32'hA5C3_0F96, 4'hF, rd, er, wt);
    acc(0, 10'h010, 0, 4'hF, rd, er, wt);
    chk("R1 hdr 0x010", rd, 32'h4433_2211);
    chk("R1 byte 0x010 lane0", {24'h0, rd[7:0]}, 32'h11);
    acc(0, 10'h0FC, 0, 4'hF, rd, er, wt); chk("R1 hdr 0x0FC", rd, 32'hA5C3_0F96);

    // R3 / R4
    acc(1, 10'h1C0, 32'hDEAD_BEEF, 4'hF, rd, er, wt);
    acc(0, 10'h1C0, 0, 4'hF, rd, er, wt); chk("R3 caddr", rd, 32'hDEAD_BEEF);
    acc(1, 10'h1C4, 32'hFFFF_FFFF, 4'hF, rd, er, wt);
    acc(0, 10'h1C4, 0, 4'hF, rd, er, wt); chk("R4 mbase mask", rd, 32'hFF00_0001);

    // R5 / R6 relocation and ignored writes
    acc(1, 10'h1C8, 32'h1234_5679, 4'hF, rd, er, wt);
    acc(0, 10'h1C8, 0, 4'hF, rd, er, wt); chk("R5 iobase moved", rd, 32'h1234_0001);
    acc(1, 10'h1C8, 32'h1234_0000, 4'hF, rd, er, wt);
    acc(0, 10'h1C8, 0, 4'hF, rd, er, wt); chk("R5 bit0-only ignored", rd, 32'h1234_0001);
    cpu_addr = 32'h1234_0000; @(negedge clk); #6;
    chk("R6 window low edge", {31'h0, io_hit}, 32'h1);
    cpu_addr = 32'h1237_FFFF; @(negedge clk); #6;
    chk("R6 window top edge", {31'h0, io_hit}, 32'h1);
    cpu_addr = 32'h1238_0000; @(negedge clk); #6;
    chk("R6 above window", {31'h0, io_hit}, 32'h0);
    cpu_addr = 32'h1233_FFFF; @(negedge clk); #6;
    chk("R6 below window", {31'h0, io_hit}, 32'h0);

    // R7 configuration write
    acc(1, 10'h1C0, 32'h8000_0810, 4'hF, rd, er, wt);
    acc(1, 10'h220, 32'hCAFE_F00D, 4'hF, rd, er, wt);
    chk("R7 wait cycles", wt, LAT);
    chk("R7 eng writes", eng_wr, 1);
    chk("R7 eng addr", eng_addr, 32'h8000_0810);
    chk("R7 eng data", eng_data, 32'hCAFE_F00D);

    // R8 configuration read
    acc(1, 10'h1C0, 32'h8000_1004, 4'hF, rd, er, wt);
    acc(0, 10'h220, 0, 4'hF, rd, er, wt);
    chk("R8 read data", rd, 32'h8000_1004 ^ 32'h5A5A_0F0F);
    chk("R8 eng reads", eng_rd, 1);
    chk("R8 wait cycles", wt, LAT);

    // R9 unmapped offsets
    acc(1, 10'h100, 32'hFFFF_FFFF, 4'hF, rd, er, wt);
    acc(1, 10'h1CC, 32'hFFFF_FFFF, 4'hF, rd, er, wt);
    acc(1, 10'h224, 32'hFFFF_FFFF, 4'hF, rd, er, wt);
    acc(0, 10'h100, 0, 4'hF, rd, er, wt); chk("R9 read 0x100", rd, 32'h0);
    acc(0, 10'h3FC, 0, 4'hF, rd, er, wt); chk("R9 read 0x3FC", rd, 32'h0);
    acc(0, 10'h1C0, 0, 4'hF, rd, er, wt); chk("R9 caddr untouched", rd, 32'h8000_1004);
    acc(0, 10'h1C8, 0, 4'hF, rd, er, wt); chk("R9 iobase untouched", rd, 32'h1234_0001);
    acc(0, 10'h000, 0, 4'hF, rd, er, wt); chk("R9 hdr untouched", rd, 32'h0);

    // R10 partial byte enables
    acc(1, 10'h1C0, 32'h0000_0000, 4'h7, rd, er, wt);
    chk("R10 err pulse", {31'h0, er}, 32'h1);
    chk("R10 no wait", wt, 0);
    acc(0, 10'h1C0, 0, 4'hF, rd, er, wt); chk("R10 caddr kept", rd, 32'h8000_1004);
    chk("R10 full access no err", {31'h0, er}, 32'h0);
    acc(1, 10'h220, 32'h1111_1111, 4'h1, rd, er, wt);
    chk("R10 port err", {31'h0, er}, 32'h1);
    chk("R10 no engine write", eng_wr, 1);

    // R11 interrupt routing: slots -> lines 1,2,1,0
    slot_fn = {8'h07, 8'h28, 8'h10, 8'h08};
    for (int p = 0; p < 16; p++) begin
      slot_irq = 4'(p); @(negedge clk); #6;
      chk("R11 irq pattern", {28'h0, irq}, {28'h0, irq_exp()});
    end
    slot_fn = {8'hF8, 8'h3B, 8'h00, 8'h1F};
    slot_irq = 4'b1010; @(negedge clk); #6;
    chk("R11 remap", {28'h0, irq}, {28'h0, 4'b1001});

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule